// File: doc/BRIEF.md
# Quarter-Table Constant Multiplier

This block multiplies an unsigned input word by a coefficient fixed at build time. It does not use an array multiplier or a table with one product per input value. Each chunk of the input is folded around the midpoint of its range, giving a signed offset. The offset's magnitude is split into an odd factor and a power of two. Only the odd multiples of the coefficient's odd part are kept in a small constant table, which needs 2^(L-2) entries for an L-bit chunk. The output is rebuilt in three steps: a left shift, a carry-free sign flip of the odd table word, and the addition of a constant midpoint product.

The pipeline has two register stages and accepts one operand per cycle. The first stage maps the address and reads the table. The second stage shifts, applies the sign, adds the offset and, when the operand is split into several chunks, merges the chunk products. The table contents are computed at elaboration from the coefficient parameter. Operands wider than one chunk are handled by replicating the chunk path and adding the partial products at shifts that are multiples of the chunk width.

Top module: `rlut_mult`

## Requirements
- R1: When `in_valid` is high at a clock edge, `out_p` equals COEF × `in_x` (exact, full width) after the second following edge.
- R2: `out_valid` equals `in_valid` delayed by exactly two clock edges, and an operand may be presented on every cycle.
- R3: The chunk midpoint input 2^(CHUNK_W-1) (128 for 8-bit chunks) has a folded magnitude of zero and yields exactly COEF × 2^(CHUNK_W-1).
- R4: The range ends are exact. Input 0 (folded magnitude 2^(CHUNK_W-1), reached with the sign reversed) gives 0. The all-ones input gives COEF × (2^CHUNK_W − 1).
- R5: A cycle with `in_valid` low does not disturb `out_p`: two edges later the output still holds the last product.
- R6: While `rst_n` is low, `out_valid` and `out_p` are 0 after the next edge.
- R7: With NUM_CHUNKS = 2, a 16-bit operand split into two 8-bit chunks gives COEF × `in_x`, with the upper chunk's product weighted by 2^8.
- R8: The extreme coefficients 0, 1 and 2^COEF_W − 1 give exact products. Coefficient 0 gives 0 for every input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand qualifier |
| in_x | input | CHUNK_W*NUM_CHUNKS | Unsigned operand |
| out_valid | output | 1 | Product qualifier, two cycles after `in_valid` |
| out_p | output | CHUNK_W*NUM_CHUNKS+COEF_W | Registered product, held between valid results |

## Verification
The bench builds five copies of the block. Four use one 8-bit chunk and 12-bit coefficients of 2730, 0, 1 and 4095. The even coefficient exercises the path that factors out the coefficient's trailing zeros, and the other three reach the zero table, the identity table and the widest table words. The fifth copy uses two 8-bit chunks and coefficient 3001, which brings the chunk merge and 16-bit corner operands within reach. Every 8-bit input value passes through each single-chunk copy, followed by random operands with valid gaps that exercise output holding.

// File: rtl/rlm_pkg.sv
package rlm_pkg;

    // index of the lowest set bit among the low w bits; 0 when none are set
    function automatic int unsigned low_one(input logic [31:0] v, input int unsigned w);
        int unsigned r;
        r = 0;
        for (int i = 31; i >= 0; i--) begin
            if (i < int'(w) && v[i]) r = i;
        end
        return r;
    endfunction

endpackage

// File: rtl/rlm_fold.sv
module rlm_fold #(
    parameter int CHUNK_W = 8,
    localparam int KW = $clog2(CHUNK_W),
    localparam int AW = CHUNK_W - 2
) (
    input  logic [CHUNK_W-1:0] x,
    output logic [AW-1:0]      idx,
    output logic [KW-1:0]      shamt,
    output logic               neg,
    output logic               zero
);
    localparam logic [CHUNK_W-1:0] HALF = CHUNK_W'(1) << (CHUNK_W - 1);

    logic [CHUNK_W-1:0] mag;
    int unsigned        k;

    always_comb begin
        // signed offset from midpoint: upper half positive, lower half negative
        if (x[CHUNK_W-1]) mag = {1'b0, x[CHUNK_W-2:0]};
        else              mag = HALF - x;
        neg   = ~x[CHUNK_W-1];
        zero  = (mag == '0);
        k     = rlm_pkg::low_one(32'(mag), CHUNK_W);
        shamt = KW'(k);
        // odd factor m = mag >> k; stored at (m-1)/2 = mag >> (k+1)
        idx   = AW'(mag >> (k + 1));
    end
endmodule

// File: rtl/rlm_odd_rom.sv
module rlm_odd_rom #(
    parameter int CHUNK_W = 8,
    parameter int COEF_W  = 12,
    parameter logic [COEF_W-1:0] COEF = '0,
    localparam int AW    = CHUNK_W - 2,
    localparam int DEPTH = 1 << AW,
    localparam int EW    = COEF_W + CHUNK_W - 1
) (
    input  logic [AW-1:0] idx,
    output logic [EW-1:0] entry
);
    localparam int unsigned CT = rlm_pkg::low_one(32'(COEF), COEF_W);
    localparam logic [EW-1:0] CODD = EW'(COEF >> CT);

    logic [EW-1:0] rom [DEPTH];

    // entry i holds odd multiple (2i+1) of the coefficient's odd part
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
        assign rom[gi] = CODD * EW'(2 * gi + 1);
    end

    assign entry = rom[idx];
endmodule

// File: rtl/rlm_rebuild.sv
module rlm_rebuild #(
    parameter int CHUNK_W = 8,
    parameter int COEF_W  = 12,
    parameter logic [COEF_W-1:0] COEF = '0,
    localparam int KW  = $clog2(CHUNK_W),
    localparam int EW  = COEF_W + CHUNK_W - 1,
    localparam int PCW = COEF_W + CHUNK_W
) (
    input  logic [EW-1:0]  entry,
    input  logic [KW-1:0]  shamt,
    input  logic           neg,
    input  logic           zero,
    output logic [PCW-1:0] part
);
    localparam int unsigned CT = rlm_pkg::low_one(32'(COEF), COEF_W);
    localparam bit NULL_COEF = (COEF == '0);
    localparam logic [PCW-1:0] OFFSET = PCW'(COEF) << (CHUNK_W - 1);

    logic [PCW-1:0] ext, flipped, term;

    always_comb begin
        ext = PCW'(entry);
        // odd word: negation is inversion of all bits above bit 0, no carry chain
        if (neg) flipped = {~ext[PCW-1:1], 1'b1};
        else     flipped = ext;
        if (zero || NULL_COEF) term = '0;
        else                   term = flipped << (int'(shamt) + int'(CT));
        part = OFFSET + term;
    end
endmodule

// File: rtl/rlut_mult.sv
module rlut_mult #(
    parameter int CHUNK_W    = 8,
    parameter int NUM_CHUNKS = 1,
    parameter int COEF_W     = 12,
    parameter logic [COEF_W-1:0] COEF = 12'd2730,
    localparam int IW = CHUNK_W * NUM_CHUNKS,
    localparam int PW = IW + COEF_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [IW-1:0] in_x,
    output logic          out_valid,
    output logic [PW-1:0] out_p
);
    localparam int KW  = $clog2(CHUNK_W);
    localparam int AW  = CHUNK_W - 2;
    localparam int EW  = COEF_W + CHUNK_W - 1;
    localparam int PCW = COEF_W + CHUNK_W;

    typedef struct packed {
        logic                         vld;
        logic [NUM_CHUNKS-1:0][EW-1:0] ent;
        logic [NUM_CHUNKS-1:0][KW-1:0] sh;
        logic [NUM_CHUNKS-1:0]         neg;
        logic [NUM_CHUNKS-1:0]         zr;
    } rd_stage_t;

    typedef struct packed {
        logic          vld;
        logic [PW-1:0] prod;
    } out_stage_t;

    typedef struct packed {
        rd_stage_t  rd;
        out_stage_t os;
    } pipe_t;

    pipe_t st_d, st_q;

    logic [NUM_CHUNKS-1:0][AW-1:0]  idx_w;
    logic [NUM_CHUNKS-1:0][KW-1:0]  sh_w;
    logic [NUM_CHUNKS-1:0]          neg_w;
    logic [NUM_CHUNKS-1:0]          zr_w;
    logic [NUM_CHUNKS-1:0][EW-1:0]  ent_w;
    logic [NUM_CHUNKS-1:0][PCW-1:0] part_w;

    for (genvar gc = 0; gc < NUM_CHUNKS; gc++) begin : g_chunk
        rlm_fold #(.CHUNK_W(CHUNK_W)) u_fold (
            .x     (in_x[gc*CHUNK_W +: CHUNK_W]),
            .idx   (idx_w[gc]),
            .shamt (sh_w[gc]),
            .neg   (neg_w[gc]),
            .zero  (zr_w[gc])
        );
        rlm_odd_rom #(.CHUNK_W(CHUNK_W), .COEF_W(COEF_W), .COEF(COEF)) u_rom (
            .idx   (idx_w[gc]),
            .entry (ent_w[gc])
        );
        rlm_rebuild #(.CHUNK_W(CHUNK_W), .COEF_W(COEF_W), .COEF(COEF)) u_rebuild (
            .entry (st_q.rd.ent[gc]),
            .shamt (st_q.rd.sh[gc]),
            .neg   (st_q.rd.neg[gc]),
            .zero  (st_q.rd.zr[gc]),
            .part  (part_w[gc])
        );
    end

    always_comb begin
        logic [PW-1:0] acc;
        st_d = st_q;
        // stage 1: address mapping and table read
        st_d.rd.vld = in_valid;
        if (in_valid) begin
            st_d.rd.ent = ent_w;
            st_d.rd.sh  = sh_w;
            st_d.rd.neg = neg_w;
            st_d.rd.zr  = zr_w;
        end
        // stage 2: shift, sign reversal, offset, chunk merge
        acc = '0;
        for (int c = 0; c < NUM_CHUNKS; c++) begin
            acc = acc + (PW'(part_w[c]) << (c * CHUNK_W));
        end
        st_d.os.vld = st_q.rd.vld;
        if (st_q.rd.vld) st_d.os.prod = acc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.os.vld;
    assign out_p     = st_q.os.prod;
endmodule

// File: rtl/rlut_mult_chk.sv
module rlut_mult_chk #(
    parameter int CHUNK_W    = 8,
    parameter int NUM_CHUNKS = 1,
    parameter int COEF_W     = 12,
    parameter logic [COEF_W-1:0] COEF = '0,
    localparam int IW = CHUNK_W * NUM_CHUNKS,
    localparam int PW = IW + COEF_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [IW-1:0] in_x,
    input logic          out_valid,
    input logic [PW-1:0] out_p
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);                                   // R2
    AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid);                                 // R2
    AST_EXACT_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 (out_p == PW'(COEF) * PW'($past(in_x, 2))));   // R1
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 $stable(out_p));                             // R5
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_p == '0));                       // R6
endmodule

bind rlut_mult rlut_mult_chk #(
    .CHUNK_W(CHUNK_W), .NUM_CHUNKS(NUM_CHUNKS), .COEF_W(COEF_W), .COEF(COEF)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x),
    .out_valid(out_valid), .out_p(out_p)
);

// File: tb/sim_rlut_mult.sv
module sim_rlut_mult;
    localparam int CLK_PERIOD = 10;
    localparam int NI = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vin = 1'b0;
    logic [7:0]  x8  = '0;
    logic [15:0] x16 = '0;

    logic [NI-1:0] ov;
    logic [19:0] p0, p1, p2, p3;
    logic [27:0] p4;

    int unsigned coef [NI] = '{2730, 0, 1, 4095, 3001};
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // input history: [1] driven one negedge ago, [2] two ago
    logic v_h1 = 1'b0, v_h2 = 1'b0;
    logic [15:0] x8_h1 = '0, x8_h2 = '0, x16_h1 = '0, x16_h2 = '0;
    longint unsigned last_p [NI] = '{0, 0, 0, 0, 0};

    always #(CLK_PERIOD/2) clk = ~clk;

    rlut_mult #(.COEF(12'd2730)) u0 (.clk(clk), .rst_n(rst_n), .in_valid(vin), .in_x(x8),
        .out_valid(ov[0]), .out_p(p0));
    rlut_mult #(.COEF(12'd0)) u1 (.clk(clk), .rst_n(rst_n), .in_valid(vin), .in_x(x8),
        .out_valid(ov[1]), .out_p(p1));
    rlut_mult #(.COEF(12'd1)) u2 (.clk(clk), .rst_n(rst_n), .in_valid(vin), .in_x(x8),
        .out_valid(ov[2]), .out_p(p2));
    rlut_mult #(.COEF(12'd4095)) u3 (.clk(clk), .rst_n(rst_n), .in_valid(vin), .in_x(x8),
        .out_valid(ov[3]), .out_p(p3));
    rlut_mult #(.NUM_CHUNKS(2), .COEF(12'd3001)) u4 (.clk(clk), .rst_n(rst_n), .in_valid(vin),
        .in_x(x16), .out_valid(ov[4]), .out_p(p4));

    function automatic longint unsigned model(int id, longint unsigned x);
        return longint'(coef[id]) * x;
    endfunction

    function automatic longint unsigned port_p(int id);
        case (id)
            0: return longint'(p0);
            1: return longint'(p1);
            2: return longint'(p2);
            3: return longint'(p3);
            default: return longint'(p4);
        endcase
    endfunction

    task automatic check(string req, longint unsigned act, longint unsigned exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_outputs();
        for (int id = 0; id < NI; id++) begin
            longint unsigned xin, exp;
            string tag;
            xin = (id == 4) ? longint'(x16_h2) : longint'(x8_h2);
            check("R2 valid", longint'(ov[id]), longint'(v_h2));
            if (v_h2) begin
                exp = model(id, xin);
                if (id == 4)                         tag = "R7 two-chunk";
                else if (xin == 128)                 tag = "R3 midpoint";
                else if (xin == 0 || xin == 255)     tag = "R4 range end";
                else if (id != 0)                    tag = "R8 extreme coef";
                else                                 tag = "R1 product";
                check(tag, port_p(id), exp);
                last_p[id] = exp;
            end else begin
                check("R5 hold", port_p(id), last_p[id]);
            end
        end
    endtask

    task automatic step(logic v, logic [7:0] a, logic [15:0] b);
        @(negedge clk);
        check_outputs();
        v_h2 = v_h1; x8_h2 = x8_h1; x16_h2 = x16_h1;
        vin = v; x8 = a; x16 = b;
        v_h1 = v; x8_h1 = {8'd0, a}; x16_h1 = b;
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R6: reset state
        for (int id = 0; id < NI; id++) begin
            check("R6 reset valid", longint'(ov[id]), 0);
            check("R6 reset product", port_p(id), 0);
        end
        rst_n = 1'b1;
        // R1/R3/R4/R8: full sweep of 8-bit operands, back to back (R2)
        for (int i = 0; i < 256; i++) step(1'b1, 8'(i), 16'($urandom));
        // R7: two-chunk corners
        step(1'b1, 8'd0,   16'h0000);
        step(1'b1, 8'd255, 16'hFFFF);
        step(1'b1, 8'd128, 16'h8080);
        step(1'b1, 8'd127, 16'h0080);
        step(1'b1, 8'd1,   16'h8000);
        step(1'b1, 8'd129, 16'h00FF);
        step(1'b1, 8'd64,  16'hFF00);
        // R5: idle gap then resume
        step(1'b0, 8'd9, 16'h1234);
        step(1'b0, 8'd77, 16'h4321);
        step(1'b1, 8'd200, 16'h7F7F);
        // random mix with gaps
        for (int i = 0; i < 800; i++) begin
            step(($urandom % 10) < 7, 8'($urandom), 16'($urandom));
        end
        step(1'b0, 8'd0, 16'd0);
        step(1'b0, 8'd0, 16'd0);
        step(1'b0, 8'd0, 16'd0);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule